// File: doc/BRIEF.md
# Integer ALU with Immediate Forming

This block is the combinational integer execution stage of a 32-bit core. It takes an operation code, two register operands, a 16-bit immediate and a flag that selects the immediate as the second operand, and it produces one result word in the same cycle. The operations are bitwise logic, add and subtract, the full set of signed and unsigned comparisons, shifts and rotates, and the moves that load an immediate into the low or the high half-word.

Each operation decides how the immediate becomes a 32-bit operand. Logical operations zero-extend it. Arithmetic operations and signed comparisons sign-extend it. Unsigned comparisons zero-fill it. The high-half logical forms and the high move put it in the upper half-word. A few operations have no immediate form, and for these the select flag is ignored. Comparisons are derived from a single subtractor: the carry decides the unsigned result and the sign and overflow decide the signed result.

Top module: `int_alu`

## Requirements
- R1: With op_i AND=0, OR=1, XOR=2, NOR=3 and use_imm_i=0, result_o is the bitwise combination of a_i and b_i.
- R2: With op_i AND=0, OR=1 or XOR=2 and use_imm_i=1, the second operand is imm_i zero-extended to 32 bits.
- R3: With op_i ANDH=24, ORH=25 or XORH=26, the second operand is imm_i placed in bits 31:16 with bits 15:0 zero, whatever use_imm_i is.
- R4: op_i ADD=4 gives a_i plus the operand and SUB=5 gives a_i minus it, both modulo 2^32; with use_imm_i=1 the operand is imm_i sign-extended.
- R5: Comparisons give exactly 1 when true and 0 when false: EQ=6, NE=7, signed LT=8, unsigned LTU=9, LE=10, LEU=11, GT=12, GTU=13, GE=14, GEU=15, each comparing a_i against the second operand.
- R6: With use_imm_i=1, EQ, NE and the signed comparisons sign-extend imm_i, and the unsigned comparisons zero-extend it.
- R7: SLL=16 and SRL=17 shift a_i and fill with zeros, SRA=18 replicates bit 31; the amount is the low 5 bits of b_i, or of imm_i when use_imm_i=1.
- R8: ROL=19 rotates a_i left by the low 5 bits of b_i or of imm_i (use_imm_i=1); ROR=20 rotates a_i right by the low 5 bits of b_i and ignores use_imm_i and imm_i.
- R9: MOVHI=21 returns imm_i in bits 31:16 with zeros below, MOVUI=22 returns imm_i zero-extended, MOVI=23 returns imm_i sign-extended; a_i and b_i do not matter.
- R10: Any op_i value from 27 to 31 returns zero.
- R11: NOR=3 always uses b_i as its second operand; use_imm_i and imm_i have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First register operand, also the shifted or rotated value |
| b_i | input | 32 | Second register operand, also the register shift amount |
| imm_i | input | 16 | Immediate field |
| use_imm_i | input | 1 | Selects the formed immediate as the second operand |
| result_o | output | 32 | Result word |

## Verification
Every operation is driven in both operand modes with an immediate whose top bit is set, so that zero-extension, sign-extension and high-half placement yield different results and a wrong choice shows at once. Comparisons use operand pairs that straddle the sign boundary (minus one against one, the most negative against the most positive value) so that signed and unsigned orderings disagree and the overflow case of the subtractor is exercised, plus equal pairs that separate the strict from the non-strict forms. Shift amounts above 31 and an arithmetic shift of a negative word separate the 5-bit masking and the fill rules, and a rotate right with a different immediate shows that the immediate is ignored there. Undefined codes with all-ones operands confirm a zero result.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_AND   = 5'd0,
    OP_OR    = 5'd1,
    OP_XOR   = 5'd2,
    OP_NOR   = 5'd3,
    OP_ADD   = 5'd4,
    OP_SUB   = 5'd5,
    OP_EQ    = 5'd6,
    OP_NE    = 5'd7,
    OP_LT    = 5'd8,
    OP_LTU   = 5'd9,
    OP_LE    = 5'd10,
    OP_LEU   = 5'd11,
    OP_GT    = 5'd12,
    OP_GTU   = 5'd13,
    OP_GE    = 5'd14,
    OP_GEU   = 5'd15,
    OP_SLL   = 5'd16,
    OP_SRL   = 5'd17,
    OP_SRA   = 5'd18,
    OP_ROL   = 5'd19,
    OP_ROR   = 5'd20,
    OP_MOVHI = 5'd21,
    OP_MOVUI = 5'd22,
    OP_MOVI  = 5'd23,
    OP_ANDH  = 5'd24,
    OP_ORH   = 5'd25,
    OP_XORH  = 5'd26
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2,
    SH_ROT   = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    IMM_ZERO = 2'd0,
    IMM_SIGN = 2'd1,
    IMM_HIGH = 2'd2,
    IMM_NONE = 2'd3
  } imm_form_e;
endpackage

// File: rtl/int_alu_opnd.sv
module int_alu_opnd
  import int_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [W-1:0]     b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  output logic [W-1:0]     opnd_o
);
  localparam int PAD_W = W - IMM_W;

  imm_form_e form;
  logic      force_imm;

  // per-opcode choice of immediate forming
  always_comb begin
    force_imm = 1'b0;
    unique case (op_i)
      OP_AND, OP_OR, OP_XOR:            form = IMM_ZERO;
      OP_LTU, OP_LEU, OP_GTU, OP_GEU:   form = IMM_ZERO;
      OP_SLL, OP_SRL, OP_SRA, OP_ROL:   form = IMM_ZERO;
      OP_ADD, OP_SUB, OP_EQ, OP_NE:     form = IMM_SIGN;
      OP_LT, OP_LE, OP_GT, OP_GE:       form = IMM_SIGN;
      OP_ANDH, OP_ORH, OP_XORH: begin
        form      = IMM_HIGH;
        force_imm = 1'b1;
      end
      default:                          form = IMM_NONE;
    endcase
  end

  always_comb begin
    opnd_o = b_i;
    if (use_imm_i || force_imm) begin
      unique case (form)
        IMM_ZERO: opnd_o = {{PAD_W{1'b0}}, imm_i};
        IMM_SIGN: opnd_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
        IMM_HIGH: opnd_o = {imm_i, {PAD_W{1'b0}}};
        default:  opnd_o = b_i;
      endcase
    end
  end
endmodule

// File: rtl/int_alu_arith.sv
module int_alu_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         eq_o,
  output logic         lt_o,
  output logic         ltu_o
);
  logic [W:0]   full;
  logic [W-1:0] b_x;
  logic         ovf;

  assign b_x   = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, sub_i};
  assign sum_o = full[W-1:0];

  // flags are meaningful only when sub_i is set
  assign ovf   = (a_i[W-1] ^ b_i[W-1]) & (full[W-1] ^ a_i[W-1]);
  assign lt_o  = full[W-1] ^ ovf;
  assign ltu_o = ~full[W];
  assign eq_o  = (full[W-1:0] == '0);
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]         a_i,
  input  logic [$clog2(W)-1:0] amt_i,
  input  shift_kind_e          kind_i,
  input  logic                 rot_right_i,
  output logic [W-1:0]         res_o
);
  logic [2*W-1:0] dbl_l, dbl_r;

  assign dbl_l = {a_i, a_i} << amt_i;
  assign dbl_r = {a_i, a_i} >> amt_i;

  always_comb begin
    unique case (kind_i)
      SH_LEFT:  res_o = a_i << amt_i;
      SH_RIGHT: res_o = a_i >> amt_i;
      SH_ARITH: res_o = W'($signed(a_i) >>> amt_i);
      default:  res_o = rot_right_i ? dbl_r[W-1:0] : dbl_l[2*W-1:W];
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  output logic [W-1:0]     result_o
);
  localparam int SHW   = $clog2(W);
  localparam int PAD_W = W - IMM_W;

  logic [W-1:0] opnd, sum, sh_res, logic_res;
  logic         eq, lt, ltu, is_sub;
  shift_kind_e  kind;

  int_alu_opnd #(.W(W), .IMM_W(IMM_W)) u_opnd (
    .op_i      (op_i),
    .b_i       (b_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .opnd_o    (opnd)
  );

  assign is_sub = (op_i != OP_ADD);

  int_alu_arith #(.W(W)) u_arith (
    .a_i   (a_i),
    .b_i   (opnd),
    .sub_i (is_sub),
    .sum_o (sum),
    .eq_o  (eq),
    .lt_o  (lt),
    .ltu_o (ltu)
  );

  always_comb begin
    unique case (op_i)
      OP_SLL:  kind = SH_LEFT;
      OP_SRL:  kind = SH_RIGHT;
      OP_SRA:  kind = SH_ARITH;
      default: kind = SH_ROT;
    endcase
  end

  int_alu_shift #(.W(W)) u_shift (
    .a_i         (a_i),
    .amt_i       (opnd[SHW-1:0]),
    .kind_i      (kind),
    .rot_right_i (op_i == OP_ROR),
    .res_o       (sh_res)
  );

  always_comb begin
    unique case (op_i)
      OP_AND, OP_ANDH: logic_res = a_i & opnd;
      OP_OR,  OP_ORH:  logic_res = a_i | opnd;
      OP_XOR, OP_XORH: logic_res = a_i ^ opnd;
      default:         logic_res = ~(a_i | opnd);
    endcase
  end

  always_comb begin
    result_o = '0;
    unique case (op_i)
      OP_AND, OP_OR, OP_XOR, OP_NOR,
      OP_ANDH, OP_ORH, OP_XORH:        result_o = logic_res;
      OP_ADD, OP_SUB:                  result_o = sum;
      OP_EQ:                           result_o[0] = eq;
      OP_NE:                           result_o[0] = ~eq;
      OP_LT:                           result_o[0] = lt;
      OP_LTU:                          result_o[0] = ltu;
      OP_LE:                           result_o[0] = lt | eq;
      OP_LEU:                          result_o[0] = ltu | eq;
      OP_GT:                           result_o[0] = ~(lt | eq);
      OP_GTU:                          result_o[0] = ~(ltu | eq);
      OP_GE:                           result_o[0] = ~lt;
      OP_GEU:                          result_o[0] = ~ltu;
      OP_SLL, OP_SRL, OP_SRA,
      OP_ROL, OP_ROR:                  result_o = sh_res;
      OP_MOVHI:                        result_o = {imm_i, {PAD_W{1'b0}}};
      OP_MOVUI:                        result_o = {{PAD_W{1'b0}}, imm_i};
      OP_MOVI:                         result_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
      default:                         result_o = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input logic [OP_W-1:0]  op_i,
  input logic [W-1:0]     a_i,
  input logic [W-1:0]     b_i,
  input logic [IMM_W-1:0] imm_i,
  input logic             use_imm_i,
  input logic [W-1:0]     result_o
);
  localparam int SHW   = $clog2(W);
  localparam int PAD_W = W - IMM_W;

  logic [2*W-1:0] back_rot;
  logic           known, is_cmp;

  assign back_rot = {result_o, result_o} << b_i[SHW-1:0];
  assign known    = !$isunknown({op_i, a_i, b_i, imm_i, use_imm_i});
  assign is_cmp   = (op_i >= OP_EQ) && (op_i <= OP_GEU);

  always_comb begin
    if (known) begin
      assert_cmp_bool_R5: assert (!is_cmp || result_o[W-1:1] == '0)
        else $error("comparison result not 0/1");
      assert_undef_zero_R10: assert (op_i <= OP_XORH || result_o == '0)
        else $error("undefined opcode gave nonzero");
      assert_add_inverse_R4: assert (!(op_i == OP_ADD && !use_imm_i) ||
                                     (result_o - b_i) == a_i)
        else $error("add result inconsistent");
      assert_ror_inverse_R8: assert (op_i != OP_ROR || back_rot[2*W-1:W] == a_i)
        else $error("rotate right inconsistent");
      assert_movui_upper_R9: assert (op_i != OP_MOVUI ||
                                     (result_o[W-1:IMM_W] == '0 && result_o[IMM_W-1:0] == imm_i))
        else $error("unsigned move wrong");
      assert_movhi_lower_R9: assert (op_i != OP_MOVHI ||
                                     (result_o[PAD_W-1:0] == '0 && result_o[W-1:PAD_W] == imm_i))
        else $error("high move wrong");
    end
  end
endmodule

bind int_alu int_alu_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
  .op_i      (op_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .imm_i     (imm_i),
  .use_imm_i (use_imm_i),
  .result_o  (result_o)
);

// File: tb/sim_int_alu.sv
module sim_int_alu;
  // entry: {req[3:0], op[4:0], use_imm, a[31:0], b[31:0], imm[15:0], exp[31:0]}
  localparam int VW = 122;
  localparam int NV = 46;
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd1, 5'd0, 1'b0, 32'hF0F0_00FF, 32'h0FF0_0F0F, 16'h0000, 32'h00F0_000F}, // R1 and
    {4'd1, 5'd1, 1'b0, 32'hF000_0001, 32'h000F_0010, 16'h0000, 32'hF00F_0011}, // R1 or
    {4'd1, 5'd2, 1'b0, 32'hFFFF_0000, 32'h0F0F_0F0F, 16'h0000, 32'hF0F0_0F0F}, // R1 xor
    {4'd1, 5'd3, 1'b0, 32'h0000_FFFF, 32'h00FF_00FF, 16'h0000, 32'hFF00_0000}, // R1 nor
    {4'd2, 5'd0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 16'h8001, 32'h0000_8001}, // R2
    {4'd2, 5'd2, 1'b1, 32'h1234_5678, 32'hFFFF_FFFF, 16'hFFFF, 32'h1234_A987}, // R2
    {4'd2, 5'd1, 1'b1, 32'h0000_0000, 32'h0000_0000, 16'h8000, 32'h0000_8000}, // R2
    {4'd3, 5'd25, 1'b0, 32'h0000_1234, 32'hFFFF_FFFF, 16'hABCD, 32'hABCD_1234}, // R3
    {4'd3, 5'd24, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 16'h00F0, 32'h00F0_0000}, // R3
    {4'd3, 5'd26, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 16'h8001, 32'h7FFE_FFFF}, // R3
    {4'd4, 5'd4, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 32'h8000_0000}, // R4
    {4'd4, 5'd4, 1'b1, 32'h0000_0010, 32'h0000_0000, 16'hFFFF, 32'h0000_000F}, // R4
    {4'd4, 5'd5, 1'b0, 32'h0000_0005, 32'h0000_0007, 16'h0000, 32'hFFFF_FFFE}, // R4
    {4'd4, 5'd5, 1'b1, 32'h0000_0000, 32'h0000_0000, 16'h8000, 32'h0000_8000}, // R4
    {4'd4, 5'd4, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 32'h0000_0000}, // R4
    {4'd5, 5'd8, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 32'h0000_0001}, // R5
    {4'd5, 5'd9, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 32'h0000_0000}, // R5
    {4'd5, 5'd8, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0000, 32'h0000_0001}, // R5
    {4'd5, 5'd14, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0000, 32'h0000_0000}, // R5
    {4'd5, 5'd15, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0000, 32'h0000_0001}, // R5
    {4'd5, 5'd10, 1'b0, 32'h0000_0005, 32'h0000_0005, 16'h0000, 32'h0000_0001}, // R5
    {4'd5, 5'd12, 1'b0, 32'h0000_0005, 32'h0000_0005, 16'h0000, 32'h0000_0000}, // R5
    {4'd5, 5'd6, 1'b0, 32'h0000_0005, 32'h0000_0005, 16'h0000, 32'h0000_0001}, // R5
    {4'd5, 5'd7, 1'b0, 32'h0000_0005, 32'h0000_0005, 16'h0000, 32'h0000_0000}, // R5
    {4'd5, 5'd11, 1'b0, 32'h0000_0006, 32'h0000_0005, 16'h0000, 32'h0000_0000}, // R5
    {4'd5, 5'd13, 1'b0, 32'h0000_0006, 32'h0000_0005, 16'h0000, 32'h0000_0001}, // R5
    {4'd5, 5'd13, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 16'h0000, 32'h0000_0001}, // R5
    {4'd6, 5'd8, 1'b1, 32'h0000_0000, 32'h0000_0000, 16'hFFFF, 32'h0000_0000}, // R6
    {4'd6, 5'd9, 1'b1, 32'h0000_0000, 32'h0000_0000, 16'hFFFF, 32'h0000_0001}, // R6
    {4'd6, 5'd6, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 16'hFFFF, 32'h0000_0001}, // R6
    {4'd6, 5'd15, 1'b1, 32'h0001_0000, 32'h0000_0000, 16'hFFFF, 32'h0000_0001}, // R6
    {4'd7, 5'd16, 1'b0, 32'h0000_0001, 32'h0000_0024, 16'h0000, 32'h0000_0010}, // R7
    {4'd7, 5'd17, 1'b0, 32'h8000_0000, 32'h0000_0004, 16'h0000, 32'h0800_0000}, // R7
    {4'd7, 5'd18, 1'b0, 32'h8000_0000, 32'h0000_0004, 16'h0000, 32'hF800_0000}, // R7
    {4'd7, 5'd18, 1'b1, 32'h4000_0000, 32'h0000_0000, 16'h001E, 32'h0000_0001}, // R7
    {4'd7, 5'd17, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 16'h001F, 32'h0000_0001}, // R7
    {4'd8, 5'd19, 1'b0, 32'h8000_0001, 32'h0000_0001, 16'h0000, 32'h0000_0003}, // R8
    {4'd8, 5'd19, 1'b1, 32'h1234_5678, 32'h0000_0000, 16'h0008, 32'h3456_7812}, // R8
    {4'd8, 5'd20, 1'b0, 32'h0000_0001, 32'h0000_0001, 16'h0000, 32'h8000_0000}, // R8
    {4'd8, 5'd20, 1'b1, 32'h0000_0001, 32'h0000_0004, 16'h0001, 32'h1000_0000}, // R8 imm ignored
    {4'd8, 5'd19, 1'b0, 32'h0000_ABCD, 32'h0000_0020, 16'h0000, 32'h0000_ABCD}, // R8 amount 32 -> 0
    {4'd9, 5'd21, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h1234, 32'h1234_0000}, // R9
    {4'd9, 5'd22, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h8001, 32'h0000_8001}, // R9
    {4'd9, 5'd23, 1'b1, 32'h0000_0000, 32'h0000_0000, 16'h8001, 32'hFFFF_8001}, // R9
    {4'd10, 5'd27, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 32'h0000_0000}, // R10
    {4'd11, 5'd3, 1'b1, 32'h0000_0000, 32'h0000_FFFF, 16'h0000, 32'hFFFF_0000}  // R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op;
  logic [31:0] a, b, res;
  logic [15:0] imm;
  logic        use_imm;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  int_alu u0 (
    .op_i      (op),
    .a_i       (a),
    .b_i       (b),
    .imm_i     (imm),
    .use_imm_i (use_imm),
    .result_o  (res)
  );

  task automatic apply(input logic [4:0] o, input logic u, input logic [31:0] va,
                       input logic [31:0] vb, input logic [15:0] vi);
    @(negedge clk);
    op = o; use_imm = u; a = va; b = vb; imm = vi;
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] exp);
    n_run++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d got=%h exp=%h", tag, op, res, exp);
    end
  endtask

  initial begin
    op = '0; a = '0; b = '0; imm = '0; use_imm = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset idle", 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      e = VEC[i];
      apply(e[117:113], e[112], e[111:80], e[79:48], e[47:32]);
      check($sformatf("R%0d vec%0d", e[121:118], i), e[31:0]);
    end

    // R10: top undefined code
    apply(5'd31, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF);
    check("R10 op31", 32'h0);
    // R11: NOR with immediate selected versus not, same b
    apply(5'd3, 1'b1, 32'h0000_0F00, 32'h0000_00F0, 16'hFFFF);
    check("R11 nor imm ignored", 32'hFFFF_F00F);
    // R8: rotate right immediate must not be used as amount
    apply(5'd20, 1'b1, 32'h0000_0010, 32'h0000_0000, 16'h0004);
    check("R8 ror b=0", 32'h0000_0010);
    // R7: arithmetic shift of positive value fills zeros
    apply(5'd18, 1'b0, 32'h7000_0000, 32'h0000_003C, 16'h0000);
    check("R7 sra positive", 32'h0000_0007);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule